// File: doc/BRIEF.md
# Split-Panel LCD Refresh Address and Line Timing Generator

This block runs from the dot clock and produces the display-memory refresh address for a character-mapped or bit-mapped LCD. The panel is split into an upper half and a lower half. Each character clock first addresses a byte for the upper half, while the clock is low, and then a byte for the lower half, while it is high. After the visible characters of each line come eight blanking characters. During these the address keeps counting. A two-character latch strobe and a seven-character busy window are placed in the blanking interval, and the busy window tells a CPU when it can reach the memory without disturbing the picture.

In text mode, every character row of addresses is shown on Vp consecutive raster rows, and the raster index is output. In graphics mode, every line moves to fresh addresses and the raster index stays zero. The frame start address is read at the start of each frame, so rewriting it scrolls the picture: an offset of HN moves it by one row and an offset of 1 moves it by one byte. A 16-bit CPU address replaces the refresh address on the memory bus whenever the display-enable input is low.

The sequencer has three named states:
- SETUP is entered at reset. It spends Vr dot clocks computing the offset of the lower half, then moves to SHOW.
- SHOW covers the visible characters. It moves to BLANK when character HN-1 ends.
- BLANK covers the eight transfer-free characters. It returns to SHOW when character HN+7 ends. At that point the line, raster and frame counters advance.

Top module: `lcd_refresh_timer`

## Requirements
- R1: While reset is low, and for the first Vr-1 dot clocks after it is released, the outputs are fixed as follows: mem_addr equals start_addr (with disp_en high), raster is 0, and char_clk, lip, busy, frp and frame_alt are 0. On the Vr-th rising edge after release the first character starts at dot 0, character 0, line 0.
- R2: The character clock period is Hp dot clocks, with Hp = hp_m1+1 in the range 4 to 8. char_clk is low for the first ceil(Hp/2) dots of each character and high for the rest. panel_lower follows char_clk.
- R3: While char_clk is low, the refresh address is row base + character index. While char_clk is high, it is that value plus the lower-half offset.
- R4: A line lasts HN+8 characters, with HN = hn_m1+1. The character index, and with it the address, keeps counting through the eight blanking characters.
- R5: lip is high for blanking characters HN and HN+1. busy is high for characters HN+1 through HN+7. Both are low during visible characters.
- R6: In graphics mode (gfx=1), the row base advances by HN every line, raster is 0, and the lower-half offset is Vr×HN.
- R7: In text mode, raster runs 0 to Vp-1, with Vp = vp_m1+1. The row base advances by HN only after raster Vp-1. The lower-half offset is floor(Vr/Vp)×HN.
- R8: A frame is Vr lines (2×Vr panel lines), with Vr = vr_m1+1. At the frame end the row base reloads from start_addr as it is at that moment, so a new start address takes effect on the next frame. frp is high throughout line 0 of each frame. frame_alt toggles at each frame end.
- R9: When disp_en is low, mem_addr equals cpu_addr. raster and all strobes are unaffected.
- R10: All address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_addr | input | 16 | Frame start address, sampled at each frame start |
| hn_m1 | input | 7 | Characters per line minus one |
| hp_m1 | input | 3 | Dots per character minus one (3..7) |
| vp_m1 | input | 4 | Raster rows per character row minus one |
| vr_m1 | input | 8 | Lines per panel half minus one |
| gfx | input | 1 | 1 = graphics, 0 = text |
| disp_en | input | 1 | 1 = refresh address on bus, 0 = CPU address |
| cpu_addr | input | 16 | CPU address |
| mem_addr | output | 16 | Memory address bus |
| raster | output | 4 | Raster row index |
| char_clk | output | 1 | Character clock |
| panel_lower | output | 1 | 1 while addressing the lower half |
| lip | output | 1 | Line latch strobe |
| frp | output | 1 | Frame pulse |
| frame_alt | output | 1 | Alternates once per frame |
| busy | output | 1 | Blanking window usable by the CPU |

## Verification
The assertions check the following on every cycle:
- the dot counter returns to zero after a character ends;
- the character index stays within the line;
- the raster index stays below Vp;
- busy is already high when the latch strobe falls;
- frame_alt changes only at a frame wrap.

The lower-half offset, the row-base steps in each mode, the scroll taking effect a frame later, address wrap and the CPU bypass depend on configuration and history. Only the bench can show them, and it does so by comparing every output, every cycle, against a closed-form model of dot time.

// File: rtl/lcdrt_pkg.sv
package lcdrt_pkg;
    typedef enum logic [1:0] {
        ST_SETUP = 2'd0,
        ST_SHOW  = 2'd1,
        ST_BLANK = 2'd2
    } seq_state_e;

    localparam int BLANK_CHARS = 8;
    localparam int LIP_CHARS   = 2;
endpackage

// File: rtl/lcdrt_dot_timer.sv
module lcdrt_dot_timer #(
    parameter int HP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [HP_W-1:0] hp_m1,
    output logic            char_clk,
    output logic            char_end
);
    localparam int PW = HP_W + 1;

    logic [HP_W-1:0] dcnt;
    logic [PW-1:0]   pitch;
    logic [PW-1:0]   low_dots;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt <= '0;
        end else if (dcnt == hp_m1) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end

    always_comb begin
        pitch    = {1'b0, hp_m1} + PW'(1);
        low_dots = (pitch + PW'(1)) >> 1;
        char_clk = run && ({1'b0, dcnt} >= low_dots);
        char_end = run && (dcnt == hp_m1);
    end

    // R2: a finished character restarts the dot count
    a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        char_end |=> (dcnt == '0));
endmodule

// File: rtl/lcdrt_line_seq.sv
module lcdrt_line_seq
    import lcdrt_pkg::*;
#(
    parameter int AW   = 16,
    parameter int HN_W = 7,
    parameter int VP_W = 4,
    parameter int VR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   start_addr,
    input  logic [HN_W-1:0] hn_m1,
    input  logic [VP_W-1:0] vp_m1,
    input  logic [VR_W-1:0] vr_m1,
    input  logic            gfx,
    input  logic            char_end,
    output logic            run,
    output logic [AW-1:0]   upper_addr,
    output logic [AW-1:0]   lower_off,
    output logic [VP_W-1:0] raster,
    output logic            lip,
    output logic            busy,
    output logic            frp,
    output logic            frame_alt
);
    localparam int CC_W = HN_W + 1;

    seq_state_e      state_q, state_d;
    logic [CC_W-1:0] ccnt;
    logic [VR_W-1:0] lcnt;
    logic [VP_W-1:0] rcnt;
    logic [AW-1:0]   base_q;
    logic [AW-1:0]   off_q;
    logic [VR_W-1:0] calc_k;
    logic [VP_W-1:0] calc_s;
    logic            frmb_q;

    logic [CC_W-1:0] show_last;
    logic [CC_W-1:0] blank_last;
    logic [CC_W-1:0] lip_last;
    logic [AW-1:0]   hn_step;
    logic            line_end;
    logic            frame_wrap;

    always_comb begin
        show_last  = {1'b0, hn_m1};
        blank_last = show_last + CC_W'(BLANK_CHARS);
        lip_last   = show_last + CC_W'(LIP_CHARS);
        hn_step    = AW'(hn_m1) + AW'(1);
        line_end   = (state_q == ST_BLANK) && char_end && (ccnt == blank_last);
        frame_wrap = line_end && (lcnt == vr_m1);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETUP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP: if (calc_k == vr_m1)                       state_d = ST_SHOW;
            ST_SHOW:  if (char_end && ccnt == show_last)         state_d = ST_BLANK;
            ST_BLANK: if (char_end && ccnt == blank_last)        state_d = ST_SHOW;
            default:                                             state_d = ST_SETUP;
        endcase
    end

    // lower-half offset, accumulated once after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_k <= '0;
            calc_s <= '0;
            off_q  <= '0;
        end else if (state_q == ST_SETUP) begin
            calc_k <= calc_k + 1'b1;
            if (gfx) begin
                off_q <= off_q + hn_step;
            end else if (calc_s == vp_m1) begin
                calc_s <= '0;
                off_q  <= off_q + hn_step;
            end else begin
                calc_s <= calc_s + 1'b1;
            end
        end
    end

    // character, line, raster and row-base counters
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_SETUP) begin
            ccnt   <= '0;
            lcnt   <= '0;
            rcnt   <= '0;
            base_q <= start_addr;
            if (!rst_n) begin
                frmb_q <= 1'b0;
            end
        end else if (char_end) begin
            if (line_end) begin
                ccnt <= '0;
                if (lcnt == vr_m1) begin
                    lcnt   <= '0;
                    rcnt   <= '0;
                    base_q <= start_addr;
                    frmb_q <= ~frmb_q;
                end else begin
                    lcnt <= lcnt + 1'b1;
                    if (gfx) begin
                        base_q <= base_q + hn_step;
                    end else if (rcnt == vp_m1) begin
                        rcnt   <= '0;
                        base_q <= base_q + hn_step;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
            end else begin
                ccnt <= ccnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        run        = 1'b0;
        raster     = '0;
        lip        = 1'b0;
        busy       = 1'b0;
        frp        = 1'b0;
        upper_addr = base_q + AW'(ccnt);
        lower_off  = off_q;
        frame_alt  = frmb_q;
        unique case (state_q)
            ST_SETUP: begin
                upper_addr = base_q;
            end
            ST_SHOW: begin
                run    = 1'b1;
                raster = gfx ? '0 : rcnt;
                frp    = (lcnt == '0);
            end
            ST_BLANK: begin
                run    = 1'b1;
                raster = gfx ? '0 : rcnt;
                frp    = (lcnt == '0);
                lip    = (ccnt <= lip_last);
                busy   = (ccnt >= lip_last);
            end
            default: ;
        endcase
    end

    // R4: character index never runs past the blanking tail
    a_r4_char_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SETUP) |-> (ccnt <= blank_last));
    // R7: raster index stays inside the character height
    a_r7_raster_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= vp_m1);
    // R5: the busy window is already open when the latch strobe ends
    a_r5_busy_covers_lip_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lip) |-> busy);
    // R8: frame alternation only moves at a frame wrap
    a_r8_alt_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frmb_q) |-> $past(frame_wrap));
endmodule

// File: rtl/lcdrt_addr_mux.sv
module lcdrt_addr_mux #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] upper_addr,
    input  logic [AW-1:0] lower_off,
    input  logic          side_hi,
    input  logic          disp_en,
    input  logic [AW-1:0] cpu_addr,
    output logic [AW-1:0] mem_addr
);
    logic [AW-1:0] refresh_addr;

    always_comb begin
        refresh_addr = side_hi ? (upper_addr + lower_off) : upper_addr;
        mem_addr     = disp_en ? refresh_addr : cpu_addr;
    end
endmodule

// File: rtl/lcd_refresh_timer.sv
module lcd_refresh_timer #(
    parameter int AW   = 16,
    parameter int HN_W = 7,
    parameter int HP_W = 3,
    parameter int VP_W = 4,
    parameter int VR_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   start_addr,
    input  logic [HN_W-1:0] hn_m1,
    input  logic [HP_W-1:0] hp_m1,
    input  logic [VP_W-1:0] vp_m1,
    input  logic [VR_W-1:0] vr_m1,
    input  logic            gfx,
    input  logic            disp_en,
    input  logic [AW-1:0]   cpu_addr,
    output logic [AW-1:0]   mem_addr,
    output logic [VP_W-1:0] raster,
    output logic            char_clk,
    output logic            panel_lower,
    output logic            lip,
    output logic            frp,
    output logic            frame_alt,
    output logic            busy
);
    logic          run;
    logic          char_end;
    logic [AW-1:0] upper_addr;
    logic [AW-1:0] lower_off;

    lcdrt_dot_timer #(.HP_W(HP_W)) u_dot (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .hp_m1    (hp_m1),
        .char_clk (char_clk),
        .char_end (char_end)
    );

    lcdrt_line_seq #(.AW(AW), .HN_W(HN_W), .VP_W(VP_W), .VR_W(VR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .hn_m1      (hn_m1),
        .vp_m1      (vp_m1),
        .vr_m1      (vr_m1),
        .gfx        (gfx),
        .char_end   (char_end),
        .run        (run),
        .upper_addr (upper_addr),
        .lower_off  (lower_off),
        .raster     (raster),
        .lip        (lip),
        .busy       (busy),
        .frp        (frp),
        .frame_alt  (frame_alt)
    );

    lcdrt_addr_mux #(.AW(AW)) u_mux (
        .upper_addr (upper_addr),
        .lower_off  (lower_off),
        .side_hi    (char_clk),
        .disp_en    (disp_en),
        .cpu_addr   (cpu_addr),
        .mem_addr   (mem_addr)
    );

    assign panel_lower = char_clk;
endmodule

// File: tb/lcd_refresh_timer_tb.sv
module lcd_refresh_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] start_addr = '0;
    logic [6:0]  hn_m1 = '0;
    logic [2:0]  hp_m1 = 3'd3;
    logic [3:0]  vp_m1 = '0;
    logic [7:0]  vr_m1 = 8'd1;
    logic        gfx = 1'b1;
    logic        disp_en = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [15:0] mem_addr;
    logic [3:0]  raster;
    logic        char_clk, panel_lower, lip, frp, frame_alt, busy;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lcd_refresh_timer u_dut (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr), .hn_m1(hn_m1),
        .hp_m1(hp_m1), .vp_m1(vp_m1), .vr_m1(vr_m1), .gfx(gfx),
        .disp_en(disp_en), .cpu_addr(cpu_addr), .mem_addr(mem_addr),
        .raster(raster), .char_clk(char_clk), .panel_lower(panel_lower),
        .lip(lip), .frp(frp), .frame_alt(frame_alt), .busy(busy)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_addr(input int t, input int hn, input int hp, input int vp,
                                    input int vr, input bit g, input int s0, input int s1);
        int dl, ln, f, lif, c, d, st, base, up, off;
        dl   = hp * (hn + 8);
        ln   = t / dl;
        f    = ln / vr;
        lif  = ln % vr;
        c    = (t % dl) / hp;
        d    = t % hp;
        st   = (f == 0) ? s0 : s1;
        base = g ? st + lif * hn : st + (lif / vp) * hn;
        up   = (base + c) & 16'hFFFF;
        off  = g ? vr * hn : (vr / vp) * hn;
        return (d >= (hp + 1) / 2) ? ((up + off) & 16'hFFFF) : up;
    endfunction

    task automatic run_cfg(input int hn, input int hp, input int vp, input int vr,
                           input bit g, input int s0, input int s1, input int chg_t,
                           input bit rnd_en);
        int dl, n;
        @(negedge clk);
        rst_n = 1'b0; disp_en = 1'b1;
        hn_m1 = 7'(hn - 1); hp_m1 = 3'(hp - 1); vp_m1 = 4'(vp - 1); vr_m1 = 8'(vr - 1);
        gfx = g; start_addr = 16'(s0);
        @(negedge clk); @(negedge clk);
        // R1: state held in reset
        chk("R1 addr", mem_addr, s0);
        chk("R1 raster", raster, 0);
        chk("R1 strobes", {char_clk, lip, busy, frp, frame_alt}, 0);
        rst_n = 1'b1;
        for (int i = 1; i < vr; i++) begin
            @(negedge clk);
            chk("R1 setup addr", mem_addr, s0);
            chk("R1 setup strobes", {char_clk, lip, busy, frp}, 0);
        end
        dl = hp * (hn + 8);
        n  = dl * vr * 2 + dl;
        for (int t = 0; t < n; t++) begin
            int ln, lif, c, d, f;
            @(negedge clk);
            ln = t / dl; f = ln / vr; lif = ln % vr; c = (t % dl) / hp; d = t % hp;
            if (disp_en)
                chk("R3 R4 R6 R7 R10 addr", mem_addr, exp_addr(t, hn, hp, vp, vr, g, s0, s1));
            else
                chk("R9 cpu bypass", mem_addr, cpu_addr);
            chk("R2 char_clk", char_clk, (d >= (hp + 1) / 2) ? 1 : 0);
            chk("R2 side", panel_lower, (d >= (hp + 1) / 2) ? 1 : 0);
            chk(g ? "R6 raster" : "R7 raster", raster, g ? 0 : lif % vp);
            chk("R5 lip", lip, (c == hn || c == hn + 1) ? 1 : 0);
            chk("R5 busy", busy, (c >= hn + 1) ? 1 : 0);
            chk("R8 frp", frp, (lif == 0) ? 1 : 0);
            chk("R8 frame_alt", frame_alt, f & 1);
            if (t == chg_t) start_addr = 16'(s1);
            if (rnd_en) begin
                disp_en  = ($urandom % 6) != 0;
                cpu_addr = 16'($urandom);
            end
        end
        disp_en = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd24681));
        // directed corners
        run_cfg(2, 4, 1, 2, 1'b1, 16'h0000, 16'h0000, -1, 1'b0);   // minimum sizes
        run_cfg(3, 5, 2, 5, 1'b0, 16'h0040, 16'h0040, -1, 1'b0);   // R7 Vr not multiple of Vp
        run_cfg(4, 8, 1, 3, 1'b1, 16'hFFFC, 16'hFFFC, -1, 1'b0);   // R10 wrap
        run_cfg(4, 6, 3, 6, 1'b0, 16'h0100, 16'h0104, 37, 1'b0);   // R8 scroll next frame
        run_cfg(2, 4, 16, 16, 1'b0, 16'h2000, 16'h2000, -1, 1'b0); // R7 full raster range
        run_cfg(5, 7, 2, 4, 1'b1, 16'h0300, 16'h0300, -1, 1'b1);   // R9 bypass mix
        // constrained random
        for (int k = 0; k < 6; k++) begin
            int hn, hp, vp, vr, s0, s1;
            bit g;
            hn = 2 + ($urandom % 5);
            hp = 4 + ($urandom % 5);
            vp = 1 + ($urandom % 4);
            vr = 2 + ($urandom % 9);
            g  = $urandom % 2;
            s0 = $urandom % 65536;
            s1 = $urandom % 65536;
            run_cfg(hn, hp, vp, vr, g, s0, s1, 3, 1'b1);
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule